// File: doc/BRIEF.md
# Vector Register File with Width-Qualified Access

This block stores thirty-two 128-bit vector registers for a SIMD/FP datapath. It has one synchronous write port and two combinational read ports. Every access carries a 3-bit width code. A half-select flag together with a part bit lets an access reach either the low 64 bits or the high 64 bits of a register. Read data always comes out on a 128-bit bus. Every bus bit above the returned field is zero.

A whole-register access (half-select low) reads or writes 8, 16, 32, 64 or 128 bits at the low end of the register. A write of fewer than 128 bits zero-fills the rest of the register; it does not merge with the old contents. A half access with part 0 works in the same way but is limited to 64 bits or fewer. A half access with part 1 must be 64 bits wide. Such a write replaces only the upper half and keeps the lower half; such a read returns the upper half in the low 64 bits of the bus.

An access with an illegal width, or with a width that its half mode does not allow, raises that port's error flag. The block suppresses such a write and drives such a read to zero. A write lands on the rising clock edge. A read in the same cycle sees the old contents, since there is no bypass. A synchronous reset clears every register.

Top module: `vrf_regfile`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears all 32 registers, so that afterwards every legal read returns zero. A write requested while reset is high is not performed.
- R2: Width codes are 0=8, 1=16, 2=32, 3=64 and 4=128 bits. A legal non-upper read returns the low width bits of the selected register, and bus bits at and above the width are zero.
- R3: A legal write with hsel=0, or with hsel=1 and part=0, stores the value's low width bits in the register's low bits and clears every other bit of that register.
- R4: A legal upper write (hsel=1, part=1, code 3) stores the value's bits 63:0 into register bits 127:64 and leaves register bits 63:0 unchanged.
- R5: A legal upper read (hsel=1, part=1, code 3) returns register bits 127:64 on bus bits 63:0, with bus bits 127:64 zero.
- R6: Width codes 5, 6 and 7 are illegal on any port. They raise that port's error flag, suppress the write, and force the read data to zero.
- R7: With hsel=1, part=1 together with any code other than 3, or part=0 together with code 4, is illegal. It raises the error flag, suppresses the write, and forces the read data to zero.
- R8: A write takes effect at the rising edge. A read of the same register in the same cycle returns the pre-write contents, and the new contents appear from the next cycle.
- R9: The two read ports are independent, and each returns its own index, width and part selection in the same cycle.
- R10: wr_err is asserted only while wr_en is high and the write access is illegal.
- R11: With hsel=0 the part bit has no effect on either reads or writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_idx | input | 5 | Write register index |
| wr_wcode | input | 3 | Write width code |
| wr_hsel | input | 1 | Write half-select mode |
| wr_part | input | 1 | Write half choice (1 = upper) |
| wr_data | input | 128 | Write value |
| wr_err | output | 1 | Illegal write request flag |
| ra_idx | input | 5 | Read port A index |
| ra_wcode | input | 3 | Read port A width code |
| ra_hsel | input | 1 | Read port A half-select mode |
| ra_part | input | 1 | Read port A half choice |
| ra_data | output | 128 | Read port A data, zero padded |
| ra_err | output | 1 | Read port A illegal access flag |
| rb_idx | input | 5 | Read port B index |
| rb_wcode | input | 3 | Read port B width code |
| rb_hsel | input | 1 | Read port B half-select mode |
| rb_part | input | 1 | Read port B half choice |
| rb_data | output | 128 | Read port B data, zero padded |
| rb_err | output | 1 | Read port B illegal access flag |

## Verification
Several properties are checked on every cycle. Port A's padding bits stay zero, illegal codes and illegal upper widths raise the error flag with zero data, and wr_err never rises without a write request. A full write reads back on the following cycle, read data holds while no legal write happens, and everything reads zero just after reset. Some behaviours depend on old register contents or on a chain of writes, and only the bench scenarios show those. They are: the upper write keeping the lower half, the narrow write clearing bits that were set earlier, the suppression of illegal writes, and port B's independent selection.

// File: rtl/vrf_pkg.sv
package vrf_pkg;

    parameter int VEC_W  = 128;
    localparam int HALF_W = VEC_W / 2;

    typedef enum logic [2:0] {
        WC_8   = 3'd0,
        WC_16  = 3'd1,
        WC_32  = 3'd2,
        WC_64  = 3'd3,
        WC_128 = 3'd4
    } wcode_e;

    // Legality of a (width code, half mode, part) combination.
    function automatic logic access_ok(logic [2:0] code, logic hsel, logic part);
        logic known;
        known = (code <= WC_128);
        if (!known)
            return 1'b0;
        if (!hsel)
            return 1'b1;
        if (part)
            return (code == WC_64);
        return (code != WC_128);
    endfunction

    // Ones in every bit below the width selected by the code.
    function automatic logic [VEC_W-1:0] low_mask(logic [2:0] code);
        logic [VEC_W-1:0] m;
        int nb;
        nb = 8 << code;
        for (int i = 0; i < VEC_W; i++)
            m[i] = (i < nb);
        return m;
    endfunction

endpackage

// File: rtl/vrf_wr_decode.sv
module vrf_wr_decode
    import vrf_pkg::*;
(
    input  logic              en,
    input  logic [2:0]        code,
    input  logic              hsel,
    input  logic              part,
    input  logic [VEC_W-1:0]  data,
    output logic              err,
    output logic              we_lo,
    output logic              we_hi,
    output logic [HALF_W-1:0] nxt_lo,
    output logic [HALF_W-1:0] nxt_hi
);

    logic             legal;
    logic             upper;
    logic             fire;
    logic [VEC_W-1:0] masked;

    always_comb begin
        legal  = access_ok(code, hsel, part);
        upper  = hsel && part;
        fire   = en && legal;
        err    = en && !legal;
        we_hi  = fire;
        we_lo  = fire && !upper;
        masked = data & low_mask(code);
        nxt_lo = masked[HALF_W-1:0];
        nxt_hi = upper ? data[HALF_W-1:0] : masked[VEC_W-1:HALF_W];
    end

endmodule

// File: rtl/vrf_bank.sv
module vrf_bank
    import vrf_pkg::*;
#(
    parameter int NREGS = 32,
    localparam int IW   = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IW-1:0]     sel_idx,
    input  logic              we_lo,
    input  logic              we_hi,
    input  logic [HALF_W-1:0] nxt_lo,
    input  logic [HALF_W-1:0] nxt_hi,
    output logic [VEC_W-1:0]  regs [NREGS]
);

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        logic hit;
        assign hit = (sel_idx == IW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (hit) begin
                if (we_lo)
                    regs[g][HALF_W-1:0] <= nxt_lo;
                if (we_hi)
                    regs[g][VEC_W-1:HALF_W] <= nxt_hi;
            end
        end
    end

endmodule

// File: rtl/vrf_rd_port.sv
module vrf_rd_port
    import vrf_pkg::*;
#(
    parameter int NREGS = 32,
    localparam int IW   = $clog2(NREGS)
) (
    input  logic [VEC_W-1:0] regs [NREGS],
    input  logic [IW-1:0]    idx,
    input  logic [2:0]       code,
    input  logic             hsel,
    input  logic             part,
    output logic [VEC_W-1:0] data,
    output logic             err
);

    logic [VEC_W-1:0] word;
    logic             legal;

    always_comb begin
        word  = regs[idx];
        legal = access_ok(code, hsel, part);
        err   = !legal;
        if (!legal)
            data = '0;
        else if (hsel && part)
            data = {{HALF_W{1'b0}}, word[VEC_W-1:HALF_W]};
        else
            data = word & low_mask(code);
    end

endmodule

// File: rtl/vrf_regfile.sv
module vrf_regfile
    import vrf_pkg::*;
#(
    parameter int NREGS = 32,
    localparam int IW   = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [2:0]       wr_wcode,
    input  logic             wr_hsel,
    input  logic             wr_part,
    input  logic [VEC_W-1:0] wr_data,
    output logic             wr_err,
    input  logic [IW-1:0]    ra_idx,
    input  logic [2:0]       ra_wcode,
    input  logic             ra_hsel,
    input  logic             ra_part,
    output logic [VEC_W-1:0] ra_data,
    output logic             ra_err,
    input  logic [IW-1:0]    rb_idx,
    input  logic [2:0]       rb_wcode,
    input  logic             rb_hsel,
    input  logic             rb_part,
    output logic [VEC_W-1:0] rb_data,
    output logic             rb_err
);

    logic              we_lo;
    logic              we_hi;
    logic [HALF_W-1:0] nxt_lo;
    logic [HALF_W-1:0] nxt_hi;
    logic [VEC_W-1:0]  regs [NREGS];

    vrf_wr_decode u_wdec (
        .en     (wr_en),
        .code   (wr_wcode),
        .hsel   (wr_hsel),
        .part   (wr_part),
        .data   (wr_data),
        .err    (wr_err),
        .we_lo  (we_lo),
        .we_hi  (we_hi),
        .nxt_lo (nxt_lo),
        .nxt_hi (nxt_hi)
    );

    vrf_bank #(.NREGS(NREGS)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .sel_idx (wr_idx),
        .we_lo   (we_lo),
        .we_hi   (we_hi),
        .nxt_lo  (nxt_lo),
        .nxt_hi  (nxt_hi),
        .regs    (regs)
    );

    vrf_rd_port #(.NREGS(NREGS)) u_rda (
        .regs (regs),
        .idx  (ra_idx),
        .code (ra_wcode),
        .hsel (ra_hsel),
        .part (ra_part),
        .data (ra_data),
        .err  (ra_err)
    );

    vrf_rd_port #(.NREGS(NREGS)) u_rdb (
        .regs (regs),
        .idx  (rb_idx),
        .code (rb_wcode),
        .hsel (rb_hsel),
        .part (rb_part),
        .data (rb_data),
        .err  (rb_err)
    );

endmodule

// File: rtl/vrf_regfile_chk.sv
module vrf_regfile_chk
    import vrf_pkg::*;
#(
    parameter int NREGS = 32,
    localparam int IW   = $clog2(NREGS)
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [IW-1:0]    wr_idx,
    input logic [2:0]       wr_wcode,
    input logic             wr_hsel,
    input logic [VEC_W-1:0] wr_data,
    input logic             wr_err,
    input logic [IW-1:0]    ra_idx,
    input logic [2:0]       ra_wcode,
    input logic             ra_hsel,
    input logic             ra_part,
    input logic [VEC_W-1:0] ra_data,
    input logic             ra_err
);

    logic [VEC_W-1:0] ra_keep;
    logic             wr_full;
    logic             wr_any;
    logic             ra_full;

    always_comb begin
        ra_keep = (ra_hsel && ra_part) ? {{HALF_W{1'b0}}, {HALF_W{1'b1}}}
                                       : low_mask(ra_wcode);
        wr_full = wr_en && !wr_err && !wr_hsel && (wr_wcode == 3'd4);
        wr_any  = wr_en && !wr_err;
        ra_full = !ra_hsel && (ra_wcode == 3'd4);
    end

    assert_rst_clear_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !ra_err) |-> (ra_data == '0));

    assert_pad_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !ra_err |-> ((ra_data & ~ra_keep) == '0));

    assert_full_readback_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_full) && ra_full && (ra_idx == $past(wr_idx)))
        |-> (ra_data == $past(wr_data)));

    assert_bad_code_R6: assert property (@(posedge clk) disable iff (rst)
        (ra_wcode > 3'd4) |-> (ra_err && ra_data == '0));

    assert_upper_width_R7: assert property (@(posedge clk) disable iff (rst)
        (ra_hsel && ra_part && ra_wcode != 3'd3) |-> ra_err);

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_any) && $stable(ra_idx) && $stable(ra_wcode)
         && $stable(ra_hsel) && $stable(ra_part)) |-> $stable(ra_data));

    assert_err_gate_R10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> !wr_err);

endmodule

bind vrf_regfile vrf_regfile_chk #(.NREGS(NREGS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_wcode (wr_wcode),
    .wr_hsel  (wr_hsel),
    .wr_data  (wr_data),
    .wr_err   (wr_err),
    .ra_idx   (ra_idx),
    .ra_wcode (ra_wcode),
    .ra_hsel  (ra_hsel),
    .ra_part  (ra_part),
    .ra_data  (ra_data),
    .ra_err   (ra_err)
);

// File: tb/vrf_regfile_bench.sv
`timescale 1ns/1ps
module vrf_regfile_bench;

    logic         clk = 1'b0;
    logic         rst;
    logic         wr_en;
    logic [4:0]   wr_idx;
    logic [2:0]   wr_wcode;
    logic         wr_hsel;
    logic         wr_part;
    logic [127:0] wr_data;
    logic         wr_err;
    logic [4:0]   ra_idx, rb_idx;
    logic [2:0]   ra_wcode, rb_wcode;
    logic         ra_hsel, rb_hsel, ra_part, rb_part;
    logic [127:0] ra_data, rb_data;
    logic         ra_err, rb_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [127:0] mdl [32];

    always #2.5 clk = ~clk;

    vrf_regfile u_vrf_regfile (.*);

    function automatic bit legal_b(logic [2:0] c, logic h, logic p);
        if (c > 3'd4) return 0;
        if (h && p)   return c == 3'd3;
        if (h)        return c != 3'd4;
        return 1;
    endfunction

    function automatic logic [127:0] fmask(logic [2:0] c);
        int nb = 8 << c;
        if (nb >= 128) return '1;
        return (128'd1 << nb) - 128'd1;
    endfunction

    function automatic logic [127:0] exp_rd(logic [127:0] r, logic [2:0] c, logic h, logic p);
        if (!legal_b(c, h, p)) return '0;
        if (h && p) return {64'd0, r[127:64]};
        return r & fmask(c);
    endfunction

    task automatic cmp(string tag, string what, logic [127:0] got, logic [127:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Inputs are set at a negedge before the call; checks before the edge, model after it.
    task automatic run_cycle(string tag);
        logic [127:0] ea, eb;
        bit ew;
        #1;
        ea = exp_rd(mdl[ra_idx], ra_wcode, ra_hsel, ra_part);
        eb = exp_rd(mdl[rb_idx], rb_wcode, rb_hsel, rb_part);
        ew = wr_en && !legal_b(wr_wcode, wr_hsel, wr_part);
        cmp(tag, "ra_data", ra_data, ea);
        cmp(tag, "ra_err", {127'd0, ra_err}, {127'd0, !legal_b(ra_wcode, ra_hsel, ra_part)});
        cmp(tag, "rb_data", rb_data, eb);
        cmp(tag, "rb_err", {127'd0, rb_err}, {127'd0, !legal_b(rb_wcode, rb_hsel, rb_part)});
        cmp(tag, "wr_err", {127'd0, wr_err}, {127'd0, ew});
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < 32; i++) mdl[i] = '0;
        end else if (wr_en && legal_b(wr_wcode, wr_hsel, wr_part)) begin
            if (wr_hsel && wr_part) mdl[wr_idx][127:64] = wr_data[63:0];
            else                    mdl[wr_idx] = wr_data & fmask(wr_wcode);
        end
        @(negedge clk);
    endtask

    task automatic set_wr(logic en, logic [4:0] i, logic [2:0] c, logic h, logic p, logic [127:0] d);
        wr_en = en; wr_idx = i; wr_wcode = c; wr_hsel = h; wr_part = p; wr_data = d;
    endtask

    task automatic set_ra(logic [4:0] i, logic [2:0] c, logic h, logic p);
        ra_idx = i; ra_wcode = c; ra_hsel = h; ra_part = p;
    endtask

    task automatic set_rb(logic [4:0] i, logic [2:0] c, logic h, logic p);
        rb_idx = i; rb_wcode = c; rb_hsel = h; rb_part = p;
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic check_all_zero(string tag);
        for (int i = 0; i < 32; i++) begin
            set_ra(5'(i), 3'd4, 0, 0);
            set_rb(5'(31 - i), 3'd3, 1, 1);
            run_cycle(tag);
            cmp(tag, "reg clear", ra_data, 128'd0);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL R8 watchdog: run incomplete, got timeout expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        rst = 1;
        set_wr(1, 5'd3, 3'd4, 0, 0, '1);   // R1: write during reset must not land
        set_ra(0, 3'd4, 0, 0);
        set_rb(0, 3'd4, 0, 0);
        @(negedge clk);
        run_cycle("R1");
        run_cycle("R1");
        rst = 0;
        set_wr(0, 0, 0, 0, 0, '0);
        check_all_zero("R1");

        // R3: full writes to every register, R2 reads at every legal width
        for (int i = 0; i < 32; i++) begin
            set_wr(1, 5'(i), 3'd4, 0, 0, rnd128());
            set_ra(5'(i), 3'd4, 0, 0);
            run_cycle("R3");
        end
        set_wr(0, 0, 0, 0, 0, '0);
        for (int c = 0; c < 5; c++) begin
            set_ra(5'd9, 3'(c), 0, 0);
            set_rb(5'd9, 3'(c < 4 ? c : 3), 1, 0);
            run_cycle("R2");
        end

        // R3: narrow write clears the rest
        set_wr(1, 5'd5, 3'd0, 0, 0, '1);
        set_ra(5'd5, 3'd4, 0, 0);
        run_cycle("R8");                 // old contents still visible
        set_wr(0, 0, 0, 0, 0, '0);
        run_cycle("R3");
        cmp("R3", "narrow zero-extend", ra_data, 128'hff);

        // R4/R5: upper write keeps lower half
        set_wr(1, 5'd6, 3'd4, 0, 0, {64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888});
        run_cycle("R3");
        set_wr(1, 5'd6, 3'd3, 1, 1, {64'hdead, 64'hcafe_f00d_0123_4567});
        set_ra(5'd6, 3'd4, 0, 0);
        run_cycle("R4");
        set_wr(0, 0, 0, 0, 0, '0);
        set_rb(5'd6, 3'd3, 1, 1);
        run_cycle("R4");
        cmp("R4", "upper write", ra_data, {64'hcafe_f00d_0123_4567, 64'h5555_6666_7777_8888});
        cmp("R5", "upper read", rb_data, {64'd0, 64'hcafe_f00d_0123_4567});

        // R7: illegal half-mode writes suppressed
        set_wr(1, 5'd6, 3'd2, 1, 1, '1);
        run_cycle("R7");
        set_wr(1, 5'd6, 3'd4, 1, 0, '1);
        set_rb(5'd6, 3'd4, 1, 0);
        run_cycle("R7");
        set_wr(0, 0, 0, 0, 0, '0);
        run_cycle("R7");
        cmp("R7", "suppressed write", ra_data, {64'hcafe_f00d_0123_4567, 64'h5555_6666_7777_8888});

        // R6: illegal codes
        for (int c = 5; c < 8; c++) begin
            set_wr(1, 5'd6, 3'(c), 0, 0, '0);
            set_rb(5'd6, 3'(c), 0, 0);
            run_cycle("R6");
        end
        set_wr(0, 0, 0, 0, 0, '0);
        run_cycle("R6");
        cmp("R6", "suppressed write", ra_data, {64'hcafe_f00d_0123_4567, 64'h5555_6666_7777_8888});

        // R10: no error flag without request
        set_wr(0, 5'd6, 3'd7, 1, 1, '1);
        run_cycle("R10");
        cmp("R10", "wr_err idle", {127'd0, wr_err}, 128'd0);

        // R11: part ignored with hsel=0
        set_wr(1, 5'd7, 3'd4, 0, 1, {64'habcd, 64'h1234});
        set_ra(5'd7, 3'd4, 0, 1);
        run_cycle("R11");
        set_wr(0, 0, 0, 0, 0, '0);
        run_cycle("R11");
        cmp("R11", "full write with part set", ra_data, {64'habcd, 64'h1234});

        // R9: random traffic on both read ports
        for (int n = 0; n < 4000; n++) begin
            logic [2:0] c;
            c = ($urandom % 8 < 7) ? 3'($urandom % 5) : 3'($urandom % 8);
            set_wr($urandom % 2, 5'($urandom % 8), c, $urandom % 2, $urandom % 2, rnd128());
            set_ra(5'($urandom % 8), 3'($urandom % 6), $urandom % 2, $urandom % 2);
            set_rb(5'($urandom % 32), 3'($urandom % 6), $urandom % 2, $urandom % 2);
            if ($urandom % 4 == 0) begin
                set_ra(wr_idx, 3'd3, 1, 1);
                set_rb(wr_idx, 3'd3, 1, 0);
            end
            run_cycle("R9");
        end

        // R1: reset clears populated file
        set_wr(0, 0, 0, 0, 0, '0);
        rst = 1;
        run_cycle("R1");
        rst = 0;
        check_all_zero("R1");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule